// File: doc/BRIEF.md
# Two-Phase Dead-Time Gate Generator

This block drives the two diagonal switch pairs of a full bridge with two alternating, non-overlapping gate signals. A free-running phase counter divides each output period into 32 equal steps. Registered decode logic turns the first gate on during the first half of the period and the second gate on during the second half. Each output turns on only after a guard interval of two or three steps, chosen by a one-bit select, during which both gates are low.

A programmable divider sets the number of clock cycles per phase step, and so sets the output frequency. The divider value and the guard-length select are sampled only at the start of a period, so a change never produces a shortened or overlapping pulse. Deasserting the enable forces both gates low at once and parks the counter at step 0. On re-enable, the waveform starts again cleanly from the beginning of a period. All control pins are plain levels with no handshake.

Top module: `deadtime_gate_gen`

## Requirements
- R1: A synchronous reset clears both gates, the phase counter, the step divider and the held configuration to zero. After reset is released with the enable high, the first period therefore uses a divider of 0 and a guard of 2 steps, whatever the inputs show.
- R2: `gate_a` and `gate_b` are never high in the same cycle.
- R3: One phase step lasts N+1 clock cycles, where N is the held divider value. One output period is 32 steps, or 32·(N+1) cycles.
- R4: With guard length D, `gate_a` is high for steps D to 15 and `gate_b` is high for steps 16+D to 31. Each gate is therefore high for (16−D)·(N+1) consecutive cycles per period. Both gates come from flip-flops and follow the step by one clock.
- R5: `dead_sel` = 0 selects D = 2 and `dead_sel` = 1 selects D = 3. Both low gaps in a period, from `gate_a` to `gate_b` and from `gate_b` to `gate_a`, last D·(N+1) cycles.
- R6: While `enable` is low, both gates are low from the first clock edge that samples it low, and the counter is held at step 0.
- R7: After `enable` rises, counting rising clock edges that sample it high, `gate_a` is first high after edge D·(N+1)+1. This uses the divider and select values present while the block was disabled.
- R8: Changes to `div_value` and `dead_sel` while the block runs take effect only from the next step 0. The current period completes with the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low forces both gates low |
| div_value | input | DIV_W | Clock cycles per phase step minus one |
| dead_sel | input | 1 | Guard length: 0 = 2 steps, 1 = 3 steps |
| gate_a | output | 1 | Gate drive for the first diagonal switch pair |
| gate_b | output | 1 | Gate drive for the second diagonal switch pair |

## Verification
The bench builds the block with its defaults: a 16-bit divider, a 5-bit phase counter (32 steps) and guard lengths of 2 and 3 steps. It drives divider values of 0, 1, 2, 3 and 7. This keeps each period between 32 and 256 cycles, so every high time, both gaps and the full period can be measured edge to edge for both select values. The small values also reach the single-cycle-step case, where the guard is only two or three clocks wide. They also allow a mid-period change of both settings to be observed across the period boundary in a short run.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // Guard-length choice carried on dead_sel
  typedef enum logic {
    DT_SHORT = 1'b0,
    DT_LONG  = 1'b1
  } dead_mode_e;

  localparam int unsigned DTG_PHASE_W = 5;   // 32 steps per period
  localparam int unsigned DTG_DIV_W   = 16;
endpackage

// File: rtl/dtg_cfg_hold.sv
// Holds divider and guard select; reloads only when told (idle or wrap).
module dtg_cfg_hold #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             sel_in,
  output logic [DIV_W-1:0] div_q,
  output logic             sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sel_q <= 1'b0;
    end else if (load) begin
      div_q <= div_in;
      sel_q <= sel_in;
    end
  end
endmodule

// File: rtl/dtg_step_div.sv
// Produces one tick every limit+1 cycles while enabled.
module dtg_step_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3: the cycle count within a step never passes the held limit
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= limit));
endmodule

// File: rtl/dtg_phase_ctr.sv
// Phase counter across one period; flags the last tick of the period.
module dtg_phase_ctr #(
  parameter int unsigned PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap
);
  localparam logic [PHASE_W-1:0] LAST = '1;

  assign wrap = tick && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) phase <= '0;
    else if (tick)  phase <= phase + 1'b1;
  end

  // R6: disabled block parks at step 0
  a_r6_parked: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == '0));
  // R3: the step only moves on a tick
  a_r3_step_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(phase));
endmodule

// File: rtl/dtg_gate_dec.sv
// Decodes the phase into two registered gate signals.
module dtg_gate_dec
  import dtg_pkg::*;
#(
  parameter int unsigned PHASE_W    = 5,
  parameter int unsigned DEAD_SHORT = 2,
  parameter int unsigned DEAD_LONG  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] phase,
  input  logic               sel,
  output logic               gate_a,
  output logic               gate_b
);
  localparam logic [PHASE_W-1:0] HALF   = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] D_SHRT = PHASE_W'(DEAD_SHORT);
  localparam logic [PHASE_W-1:0] D_LONG = PHASE_W'(DEAD_LONG);

  dead_mode_e         mode;
  logic [PHASE_W-1:0] dead;
  logic               a_on, b_on;

  assign mode = dead_mode_e'(sel);
  assign dead = (mode == DT_LONG) ? D_LONG : D_SHRT;
  assign a_on = (phase >= dead) && (phase < HALF);
  assign b_on = (phase >= (HALF + dead));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= en && a_on;
      gate_b <= en && b_on;
    end
  end

  // R2: never both on
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(gate_a && gate_b));
  // R5: each turn-on is preceded by a cycle with the other gate low
  a_r5_gap_ab: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_b) |-> !$past(gate_a));
  a_r5_gap_ba: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_a) |-> !$past(gate_b));
  // R6: disable forces both low on the next edge
  a_r6_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_a && !gate_b));
endmodule

// File: rtl/deadtime_gate_gen.sv
module deadtime_gate_gen
  import dtg_pkg::*;
#(
  parameter int unsigned DIV_W      = DTG_DIV_W,
  parameter int unsigned PHASE_W    = DTG_PHASE_W,
  parameter int unsigned DEAD_SHORT = 2,
  parameter int unsigned DEAD_LONG  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_value,
  input  logic             dead_sel,
  output logic             gate_a,
  output logic             gate_b
);
  logic [DIV_W-1:0]   cfg_div;
  logic               cfg_sel;
  logic               tick, wrap, load;
  logic [PHASE_W-1:0] phase;

  // Settings pass in while idle or at the period boundary only
  assign load = !enable || wrap;

  dtg_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .div_in(div_value), .sel_in(dead_sel),
    .div_q(cfg_div), .sel_q(cfg_sel)
  );

  dtg_step_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(enable), .limit(cfg_div), .tick(tick)
  );

  dtg_phase_ctr #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .en(enable), .tick(tick),
    .phase(phase), .wrap(wrap)
  );

  dtg_gate_dec #(
    .PHASE_W(PHASE_W), .DEAD_SHORT(DEAD_SHORT), .DEAD_LONG(DEAD_LONG)
  ) u_dec (
    .clk(clk), .rst(rst), .en(enable), .phase(phase), .sel(cfg_sel),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  // R8: held settings cannot move mid-period while running
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (enable && !wrap) |=> ($stable(cfg_div) && $stable(cfg_sel)));
endmodule

// File: tb/test_deadtime_gate_gen.sv
module test_deadtime_gate_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [15:0] div_value;
  logic        dead_sel;
  logic        gate_a, gate_b;

  int checks = 0;
  int fails  = 0;
  int overlaps = 0;
  int cyc = 0;

  always #2 clk = ~clk;   // 250 MHz

  deadtime_gate_gen i_deadtime_gate_gen (
    .clk(clk), .rst(rst), .enable(enable), .div_value(div_value),
    .dead_sel(dead_sel), .gate_a(gate_a), .gate_b(gate_b)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && gate_a && gate_b) overlaps++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic get(input int which);
    return (which == 0) ? gate_a : gate_b;
  endfunction

  // Count negedges while the chosen gate keeps level lvl
  task automatic run_len(input int which, input logic lvl, output int n);
    n = 0;
    while (get(which) == lvl) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Align to a fresh gate_a rise, then measure one full period
  task automatic measure(output int ah, output int g1, output int bh, output int g2);
    int dummy;
    run_len(0, 1'b1, dummy);
    run_len(0, 1'b0, dummy);
    run_len(0, 1'b1, ah);
    run_len(1, 1'b0, g1);
    run_len(1, 1'b1, bh);
    run_len(0, 1'b0, g2);
  endtask

  task automatic t_reset;
    int n;
    rst = 1'b1; enable = 1'b1; div_value = 16'd5; dead_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 gate_a in reset", int'(gate_a), 0);
    chk("R1 gate_b in reset", int'(gate_b), 0);
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!gate_a && n < 100);
    // cleared config: N=0, D=2 -> first high after edge 3
    chk("R1 first rise uses cleared config", n, 3);
    run_len(0, 1'b1, n);
    chk("R1 first high time with cleared config", n, 14);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled;
    int seen = 0;
    enable = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (gate_a || gate_b) seen++;
    end
    chk("R6 gates low while disabled", seen, 0);
  endtask

  task automatic t_shape(input int n_div, input logic sel);
    int ah, g1, bh, g2, d;
    d = sel ? 3 : 2;
    enable = 1'b0; div_value = 16'(n_div); dead_sel = sel;
    @(negedge clk); @(negedge clk);
    enable = 1'b1;
    measure(ah, g1, bh, g2);
    chk($sformatf("R4 gate_a high N=%0d D=%0d", n_div, d), ah, (16 - d) * (n_div + 1));
    chk($sformatf("R5 gap a->b N=%0d D=%0d", n_div, d), g1, d * (n_div + 1));
    chk($sformatf("R4 gate_b high N=%0d D=%0d", n_div, d), bh, (16 - d) * (n_div + 1));
    chk($sformatf("R5 gap b->a N=%0d D=%0d", n_div, d), g2, d * (n_div + 1));
    chk($sformatf("R3 period N=%0d", n_div), ah + g1 + bh + g2, 32 * (n_div + 1));
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart;
    int n;
    enable = 1'b0; div_value = 16'd1; dead_sel = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!gate_a && n < 100);
    chk("R7 first rise after enable", n, 5);
    // drop enable while gate_a is high
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R6 gate_a low after disable", int'(gate_a), 0);
    chk("R6 gate_b low after disable", int'(gate_b), 0);
  endtask

  task automatic t_cfg_change;
    int ah, g1, bh, g2, dummy;
    enable = 1'b0; div_value = 16'd1; dead_sel = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    run_len(0, 1'b0, dummy);           // now at first high cycle of gate_a
    div_value = 16'd2; dead_sel = 1'b1; // change mid-period
    run_len(0, 1'b1, ah);
    run_len(1, 1'b0, g1);
    run_len(1, 1'b1, bh);
    run_len(0, 1'b0, g2);
    chk("R8 gate_a keeps old setting", ah, 28);
    chk("R8 gap keeps old setting", g1, 4);
    chk("R8 gate_b keeps old setting", bh, 28);
    chk("R8 new setting from step 0 (gap)", g2, 9);
    run_len(0, 1'b1, ah);
    chk("R8 new setting gate_a high", ah, 39);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_shape(0, 1'b0);
    t_shape(0, 1'b1);
    t_shape(1, 1'b1);
    t_shape(3, 1'b0);
    t_shape(7, 1'b1);
    t_restart();
    t_cfg_change();
    chk("R2 no overlap cycles seen", overlaps, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule